// File: doc/BRIEF.md
# Mains-Clocked Time-of-Day Counter

This block keeps the time of day as six BCD digits: seconds, minutes and hours, each split into units and tens. An external prescaler supplies a once-per-second count strobe. A separate mains-event strobe arrives at line frequency. Each digit spots its terminal code with a sparse gate. On the count that reaches it, the digit returns to zero and sets a rollover latch. That latch carries into the next digit and drives the active-low pulse outputs. Only a later mains event frees the latch. While the latch is held, the digit ignores any further count strobes.

A run control gates only the seconds count strobe. The mains event keeps releasing latches whether the clock runs or is stopped. A debounced manual-advance strobe steps the minutes-units digit through the same carry path as the seconds rollover, so hours can be set with the clock stopped. A synchronous clear input and the active-low reset both return the block to midnight.

Top module: `tod_counter`

## Requirements
- R1: Every sampled edge with `run` high and `sec_tick` high advances the seconds-units digit by one. The result is visible after that same edge. A digit steps 9 to 0 and carries one count into the digit above. All digits are 4-bit BCD.
- R2: The seconds-tens and minutes-tens digits step 5 to 0 and carry upward. The hours pair steps from 23 to 00. An hours-units carry from 9 adds one to hours-tens.
- R3: `min_pulse_n` goes low when the seconds wrap from 59 to 00. `hour_pulse_n` goes low when the minutes wrap from 59 to 00. `day_pulse_n` goes low when the time wraps from 23:59:59 to 00:00:00. Each stays low until the first `ac_tick` sampled on an edge after the one that set it.
- R4: While a digit's rollover latch is held, count strobes into that digit are dropped. An `ac_tick` on a later edge releases the latch, and after that the digit counts again.
- R5: With `run` low, `sec_tick` has no effect on any digit. Latches that are already set are still released by `ac_tick`.
- R6: Each `man_adv` strobe steps the minutes-units digit, whatever the state of `run`. It carries into minutes-tens and the hours like a seconds rollover.
- R7: A low `rst_n` or a high `clr` sampled on an edge sets the time to 00:00:00 and drives all three pulse outputs high.
- R8: Starting from 00:00:00, 86400 accepted seconds strobes give exactly 1440 minute pulses, 24 hour pulses and 1 day pulse, and the time ends at 00:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear to midnight |
| ac_tick | input | 1 | One-cycle mains event strobe; releases rollover latches |
| sec_tick | input | 1 | One-cycle once-per-second count strobe from the prescaler |
| run | input | 1 | High lets `sec_tick` count |
| man_adv | input | 1 | Debounced one-cycle strobe that steps minutes-units |
| sec_u | output | 4 | Seconds units, BCD |
| sec_t | output | 4 | Seconds tens, BCD |
| min_u | output | 4 | Minutes units, BCD |
| min_t | output | 4 | Minutes tens, BCD |
| hr_u | output | 4 | Hours units, BCD |
| hr_t | output | 4 | Hours tens, BCD |
| min_pulse_n | output | 1 | Active-low once-per-minute pulse |
| hour_pulse_n | output | 1 | Active-low once-per-hour pulse |
| day_pulse_n | output | 1 | Active-low once-per-day pulse |

## Verification
If a rollover latch gets stuck, the pulse output for that digit stays low beyond the next mains event. The digit above it then freezes at the next rollover, and that shows up within a few seconds of counting. If a latch is released early or never blocks, it shows only when strobes crowd a rollover. For that reason the bench withholds the mains event and steps the minutes by hand. A wrong terminal gate shows as a digit outside its range, or as a missing carry, on the first wrap through that code. The full-day run counts the pulses, so a single lost or extra carry anywhere in 86400 seconds changes a total.

// File: rtl/tod_pkg.sv
// Shared constants for the time-of-day counter.
// Assumes BCD digits of DIG_W bits and a 24-hour day.
package tod_pkg;
    localparam int DIG_W     = 4;
    localparam int LO_DIGITS = 4;   // sec units, sec tens, min units, min tens
    localparam int HR_T_END  = 2;   // hours tens on the last hour of the day
    localparam int HR_U_END  = 3;   // hours units on the last hour of the day

    // Highest value of a low digit: even index is a units digit, odd a tens digit.
    function automatic int last_of(input int idx);
        return (idx % 2 == 0) ? 9 : 5;
    endfunction
endpackage

// File: rtl/tod_digit.sv
// One BCD counter digit with its own rollover latch.
// Counts on `inc`. It detects the terminal code LAST+1 with a sparse AND of that
// code's set bits, and on that count returns to zero and sets the latch. The latch
// blocks further counts until `ac_tick` releases it on a later edge.
// Assumes `inc` and `ac_tick` are one-cycle strobes synchronous to clk.
module tod_digit #(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ac_tick,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         lat,
    output logic         carry
);
    localparam logic [W-1:0] TERM = W'(LAST + 1);

    logic [W-1:0] nxt;
    logic         hit;
    logic         take;

    // Next count, sparse terminal gate and accepted-count decision.
    always_comb begin
        nxt   = q + W'(1);
        hit   = ((nxt & TERM) == TERM);
        take  = inc & ~lat;
        carry = take & hit;
    end

    // Digit register: clear, step, or wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (take)
            q <= hit ? '0 : nxt;
    end

    // Rollover latch: set by the terminal gate, released by a mains event.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            lat <= 1'b0;
        else if (carry)
            lat <= 1'b1;
        else if (ac_tick)
            lat <= 1'b0;
    end

    // R2: the digit never leaves its range.
    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        q <= W'(LAST));

    // R4: a held latch freezes the digit for the next edge.
    a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (lat && !clr) |=> $stable(q));

    // R4: a mains event frees a held latch.
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lat && ac_tick && !clr) |=> !lat);

    // R3: without a mains event the latch stays set.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lat && !ac_tick && !clr) |=> lat);

    // R1: a latch is only ever set together with a wrap to zero.
    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat) |-> (q == '0));
endmodule

// File: rtl/tod_hours.sv
// Hours digit pair with the 23-to-00 wrap.
// It detects the last hour on the combined tens and units value. It keeps a units
// latch for the 9-to-0 carry into tens and a day latch for the end of the day. Either
// held latch blocks counting. `ac_tick` releases both latches on a later edge.
module tod_hours #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ac_tick,
    input  logic         inc,
    output logic [W-1:0] hu,
    output logic [W-1:0] ht,
    output logic         lat_u,
    output logic         lat_d
);
    import tod_pkg::*;

    localparam logic [W-1:0] U_TERM = W'(10);
    localparam logic [W-1:0] T_LAST = W'(HR_T_END);
    localparam logic [W-1:0] U_LAST = W'(HR_U_END);

    logic [W-1:0] nxt_u;
    logic         u_hit;
    logic         end_day;
    logic         take;

    // Units step, units terminal gate and combined last-hour detect.
    always_comb begin
        nxt_u   = hu + W'(1);
        u_hit   = ((nxt_u & U_TERM) == U_TERM);
        end_day = (ht == T_LAST) && (hu == U_LAST);
        take    = inc & ~lat_u & ~lat_d;
    end

    // Hours digits: clear, wrap the day, carry units into tens, or step units.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hu <= '0;
            ht <= '0;
        end else if (take) begin
            if (end_day) begin
                hu <= '0;
                ht <= '0;
            end else if (u_hit) begin
                hu <= '0;
                ht <= ht + W'(1);
            end else begin
                hu <= nxt_u;
            end
        end
    end

    // Units rollover latch: set on a 9-to-0 carry, released by a mains event.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            lat_u <= 1'b0;
        else if (take && u_hit && !end_day)
            lat_u <= 1'b1;
        else if (ac_tick)
            lat_u <= 1'b0;
    end

    // Day latch: set on the 23-to-00 wrap, released by a mains event.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            lat_d <= 1'b0;
        else if (take && end_day)
            lat_d <= 1'b1;
        else if (ac_tick)
            lat_d <= 1'b0;
    end

    // R2: hours stay within 00..23.
    a_r2_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
        (hu <= W'(9)) && ((ht < T_LAST) || ((ht == T_LAST) && (hu <= U_LAST))));

    // R3: the day latch rises only with the hours at 00.
    a_r3_day_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_d) |-> (hu == '0) && (ht == '0));

    // R4: a held latch freezes the hours for the next edge.
    a_r4_hours_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_u || lat_d) && !clr) |=> ($stable(hu) && $stable(ht)));
endmodule

// File: rtl/tod_counter.sv
// Time-of-day counter: seconds and minutes digits plus an hours pair.
// The count strobe gated by `run` feeds seconds units. Each wrap ripples one carry
// upward in the same cycle. `man_adv` joins the chain at minutes units. The pulse
// outputs are the inverted rollover latches of seconds tens, minutes tens and the day.
// Assumes every input strobe lasts one clk cycle.
module tod_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       ac_tick,
    input  logic       sec_tick,
    input  logic       run,
    input  logic       man_adv,
    output logic [3:0] sec_u,
    output logic [3:0] sec_t,
    output logic [3:0] min_u,
    output logic [3:0] min_t,
    output logic [3:0] hr_u,
    output logic [3:0] hr_t,
    output logic       min_pulse_n,
    output logic       hour_pulse_n,
    output logic       day_pulse_n
);
    import tod_pkg::*;

    localparam int MIN_U_IDX = 2;

    logic [DIG_W-1:0] dq    [LO_DIGITS];
    logic             lat   [LO_DIGITS];
    logic             carry [LO_DIGITS];
    logic             inc   [LO_DIGITS];
    logic             hr_lat_u;
    logic             hr_lat_d;
    logic [DIG_W-1:0] hu_q;
    logic [DIG_W-1:0] ht_q;

    // Carry chain: gated seconds strobe at the bottom, manual strobe at minutes units.
    always_comb begin
        for (int i = 0; i < LO_DIGITS; i++) begin
            if (i == 0)
                inc[i] = sec_tick & run;
            else if (i == MIN_U_IDX)
                inc[i] = carry[i-1] | man_adv;
            else
                inc[i] = carry[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < LO_DIGITS; g++) begin : g_dig
            tod_digit #(
                .W    (DIG_W),
                .LAST (last_of(g))
            ) u_dig (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr),
                .ac_tick (ac_tick),
                .inc     (inc[g]),
                .q       (dq[g]),
                .lat     (lat[g]),
                .carry   (carry[g])
            );
        end
    endgenerate

    tod_hours #(.W(DIG_W)) u_hours (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ac_tick (ac_tick),
        .inc     (carry[LO_DIGITS-1]),
        .hu      (hu_q),
        .ht      (ht_q),
        .lat_u   (hr_lat_u),
        .lat_d   (hr_lat_d)
    );

    // Output mapping: digits as held, pulses as inverted latches.
    always_comb begin
        sec_u        = dq[0];
        sec_t        = dq[1];
        min_u        = dq[2];
        min_t        = dq[3];
        hr_u         = hu_q;
        hr_t         = ht_q;
        min_pulse_n  = ~lat[1];
        hour_pulse_n = ~lat[3];
        day_pulse_n  = ~hr_lat_d;
    end

    // R5: stopped and no manual strobe means no digit moves.
    a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !man_adv && !clr) |=>
            $stable({sec_u, sec_t, min_u, min_t, hr_u, hr_t}));

    // R6: an unblocked manual strobe always moves minutes units.
    a_r6_manual_step: assert property (@(posedge clk) disable iff (!rst_n)
        (man_adv && !lat[MIN_U_IDX] && !clr) |=> (min_u != $past(min_u)));

    // R7: clear gives midnight with every pulse high.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ({sec_u, sec_t, min_u, min_t, hr_u, hr_t} == '0)
                && min_pulse_n && hour_pulse_n && day_pulse_n);

    // R3: the day pulse starts only at 00:00:00, with the hour pulse also low.
    a_r3_day_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(day_pulse_n) |->
            ({sec_u, sec_t, min_u, min_t, hr_u, hr_t} == '0) && !hour_pulse_n);

    // R4: hours units latch blocks with the hours pair (kept observable here).
    a_r4_hr_latch_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_lat_u && ac_tick && !clr) |=> !hr_lat_u);

    // R4: seconds units latch releases on a mains event.
    a_r4_sec_u_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lat[0] && ac_tick && !clr) |=> !lat[0]);
endmodule

// File: tb/sim_tod_counter.sv
// Bench for tod_counter. An integer reference model advances on every edge and is
// compared with the ports at each falling edge. Directed checks then cover stop,
// latch blocking, manual setting and clear, and a full-day run counts the pulses.
module sim_tod_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 199000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic ac_tick = 1'b0;
    logic sec_tick = 1'b0;
    logic run = 1'b0;
    logic man_adv = 1'b0;
    logic [3:0] sec_u, sec_t, min_u, min_t, hr_u, hr_t;
    logic min_pulse_n, hour_pulse_n, day_pulse_n;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit cnt_en = 1'b0;
    int n_min = 0, n_hour = 0, n_day = 0;
    bit p_min = 1'b1, p_hour = 1'b1, p_day = 1'b1;
    bit done = 1'b0;

    // Reference state: four low digits, hours as 0..23, six latch flags.
    int v [4];
    int h;
    bit lt [6];
    bit nl [6];
    bit cy;
    bit go;

    tod_counter u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ac_tick(ac_tick),
        .sec_tick(sec_tick), .run(run), .man_adv(man_adv),
        .sec_u(sec_u), .sec_t(sec_t), .min_u(min_u), .min_t(min_t),
        .hr_u(hr_u), .hr_t(hr_t), .min_pulse_n(min_pulse_n),
        .hour_pulse_n(hour_pulse_n), .day_pulse_n(day_pulse_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < 4; i++) v[i] = 0;
            h = 0;
            for (int i = 0; i < 6; i++) lt[i] = 1'b0;
        end else begin
            for (int i = 0; i < 6; i++) nl[i] = ac_tick ? 1'b0 : lt[i];
            cy = run && sec_tick;
            for (int i = 0; i < 4; i++) begin
                go = ((i == 2) ? (cy || man_adv) : cy) && !lt[i];
                cy = 1'b0;
                if (go) begin
                    if (v[i] == ((i % 2 == 0) ? 9 : 5)) begin
                        v[i] = 0;
                        nl[i] = 1'b1;
                        cy = 1'b1;
                    end else begin
                        v[i] = v[i] + 1;
                    end
                end
            end
            if (cy && !lt[4] && !lt[5]) begin
                if (h == 23) begin
                    h = 0;
                    nl[5] = 1'b1;
                end else begin
                    if (h % 10 == 9) nl[4] = 1'b1;
                    h = h + 1;
                end
            end
            for (int i = 0; i < 6; i++) lt[i] = nl[i];
        end
    end

    // Per-cycle comparison and pulse counting, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R1 seconds digits", {sec_t, sec_u}, v[1] * 16 + v[0]);
            chk("R2 minutes and hours digits", {hr_t, hr_u, min_t, min_u},
                (h / 10) * 4096 + (h % 10) * 256 + v[3] * 16 + v[2]);
            chk("R3 pulse outputs", {min_pulse_n, hour_pulse_n, day_pulse_n},
                {!lt[1], !lt[3], !lt[5]});
        end
        if (cnt_en) begin
            if (p_min && !min_pulse_n) n_min++;
            if (p_hour && !hour_pulse_n) n_hour++;
            if (p_day && !day_pulse_n) n_day++;
        end
        p_min = min_pulse_n;
        p_hour = hour_pulse_n;
        p_day = day_pulse_n;
    end

    task automatic drive(input bit a, input bit s, input bit m);
        @(negedge clk);
        ac_tick = a;
        sec_tick = s;
        man_adv = m;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0);
        cmp_en = 1'b1;
        // R7: reset state.
        chk("R7 reset digits", {hr_t, hr_u, min_t, min_u, sec_t, sec_u}, 0);
        chk("R7 reset pulses", {min_pulse_n, hour_pulse_n, day_pulse_n}, 3'b111);

        // R5: stopped clock ignores the seconds strobe.
        run = 1'b0;
        for (int k = 0; k < 5; k++) drive(1, 1, 0);
        drive(1, 0, 0);
        chk("R5 no advance while stopped", sec_u, 0);

        // R1: count to 9, then wrap into seconds tens.
        run = 1'b1;
        for (int k = 0; k < 9; k++) begin drive(1, 1, 0); drive(1, 0, 0); end
        chk("R1 units at nine", sec_u, 9);
        drive(1, 1, 0);
        drive(1, 0, 0);
        chk("R1 units wrap", {sec_t, sec_u}, 8'h10);

        // R6 and R4: manual steps, then a wrap with no mains event.
        for (int k = 0; k < 9; k++) begin drive(1, 0, 1); drive(1, 0, 0); end
        chk("R6 manual steps", min_u, 9);
        drive(0, 0, 1);
        drive(0, 0, 0);
        chk("R6 manual wrap carries", {min_t, min_u}, 8'h10);
        drive(0, 0, 1);
        drive(0, 0, 0);
        chk("R4 blocked while latched", min_u, 0);
        drive(1, 0, 0);
        drive(0, 0, 1);
        drive(0, 0, 0);
        chk("R4 counts after release", min_u, 1);

        // R2 and R3: step to 59, wrap with the mains event withheld.
        for (int k = 0; k < 48; k++) begin drive(1, 0, 1); drive(1, 0, 0); end
        chk("R2 minutes at 59", {min_t, min_u}, 8'h59);
        drive(0, 0, 1);
        drive(0, 0, 0);
        drive(0, 0, 0);
        drive(0, 0, 0);
        chk("R2 minutes wrap into hours", {hr_t, hr_u, min_t, min_u}, 16'h0100);
        chk("R3 hour pulse held without mains event", hour_pulse_n, 0);

        // R5: a mains event releases the latch while stopped.
        run = 1'b0;
        drive(1, 0, 0);
        drive(0, 0, 0);
        chk("R5 release while stopped", hour_pulse_n, 1);

        // R7: clear.
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R7 clear digits", {hr_t, hr_u, min_t, min_u, sec_t, sec_u}, 0);

        // R8: a full day of seconds with a mains event on every cycle.
        run = 1'b1;
        cnt_en = 1'b1;
        for (int k = 0; k < 86400; k++) begin drive(1, 1, 0); drive(1, 0, 0); end
        drive(1, 0, 0);
        cnt_en = 1'b0;
        chk("R8 minute pulses", n_min, 1440);
        chk("R8 hour pulses", n_hour, 24);
        chk("R8 day pulses", n_day, 1);
        chk("R8 back at midnight", {hr_t, hr_u, min_t, min_u, sec_t, sec_u}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule